// File: doc/BRIEF.md
# Request/Grant Bus Cycle Stealer

This block lets a coprocessor borrow a shared system bus from its host for a short burst of memory cycles. Bus ownership is negotiated over one shared active-low line. The coprocessor pulls the line low for one clock to ask for the bus. The host finishes its own cycle and answers with a one-clock low pulse on the same line, then stays off the bus. When the burst is done, the coprocessor pulls the line low for one more clock to hand the bus back.

A transfer is started with a start address, a word count and a direction. While it owns the bus, the block runs one bus cycle per word. Each cycle has the phases T1, T2, T3 and T4, and wait phases are added while the bus is not ready. The cycle type appears only as a 3-bit status code, which returns to passive to mark the end of a cycle. The status and address outputs have an output enable. That enable is low whenever the block does not own the bus, which models a floating output.

Top module: `busStealer`

## Requirements
- R1: After reset the block is idle. `xferBusy`, `xferDone`, `rgDriveLow` and `statusOe` are all low, and `busStatus` reads passive (111).
- R2: A `xferStart` sampled while idle, with `xferCount` from 1 to MAX_WORDS (default 8), is accepted. In the next cycle `rgDriveLow` is high for exactly one clock (the request) and `xferBusy` rises. A start with count 0, a start with count above MAX_WORDS, or any start while busy is ignored.
- R3: After the request the block waits any number of cycles. A low line (`rgIn` = 0) sampled in a waiting cycle is taken as the grant. The block's own request clock is never mistaken for a grant.
- R4: In the cycle after the grant is sampled, `statusOe` rises. `busAddr` equals the start address. `busStatus` shows the cycle code: 101 for a read (`xferWrite` = 0) or 110 for a write (`xferWrite` = 1).
- R5: Each bus cycle shows the cycle code during T1 and T2. The code is passive (111) during T3 and during any wait phases. A wait phase follows T3 or another wait phase whenever `ready` is sampled low at the end of it.
- R6: In T4 the status shows the cycle code when another word follows, and shows passive after the last word.
- R7: Each later word's `busAddr` is the previous address plus WORD_BYTES (default 2), modulo 2^AW.
- R8: After the last T4 comes a single release cycle. In it `rgDriveLow` and `xferDone` are high, and `statusOe` is low. The block is idle in the next cycle.
- R9: While `statusOe` is high, `busStatus` never takes the unused codes 000 to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferStart | input | 1 | Request a transfer this cycle |
| xferAddr | input | AW | Address of the first word |
| xferCount | input | CW | Number of words, 1 to MAX_WORDS |
| xferWrite | input | 1 | 1 = memory write, 0 = memory read |
| ready | input | 1 | Bus ready, sampled at the end of T3 and wait phases |
| rgIn | input | 1 | Sampled level of the shared request/grant line (low = pulse) |
| rgDriveLow | output | 1 | Pull the shared line low this clock |
| busStatus | output | 3 | Bus cycle status code |
| statusOe | output | 1 | Enable for status and address (low = floating) |
| busAddr | output | AW | Word address of the current bus cycle |
| xferBusy | output | 1 | A transfer is in progress |
| xferDone | output | 1 | Release cycle of a finished transfer |

## Verification
The assertions assume a well-behaved host. The host pulls the line low only while the block is waiting for a grant, the grant is one clock long, and the start inputs are stable for the cycle they are sampled. The bench host obeys this. It reacts only to a request it has seen, waits at least one clock before granting, and grants once. The only out-of-range inputs it sends are start attempts that should be ignored, namely a count of 0, a count above the maximum, and a start during a transfer. Ready is driven either always high or in a repeating low/high pattern, so wait phases appear at several points within the bursts.

// File: rtl/busStealPkg.sv
package busStealPkg;

  localparam logic [2:0] ST_READ    = 3'b101;
  localparam logic [2:0] ST_WRITE   = 3'b110;
  localparam logic [2:0] ST_PASSIVE = 3'b111;

  typedef enum logic [3:0] {
    PH_IDLE, PH_REQ, PH_WAITGNT, PH_LEAD,
    PH_T1, PH_T2, PH_T3, PH_TW, PH_T4, PH_REL
  } phase_t;

  typedef struct packed {
    logic load;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/stealDatapath.sv
module stealDatapath
  import busStealPkg::*;
#(
  parameter int AW = 20,
  parameter int WORD_BYTES = 2,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] startCount,
  input  logic          startWrite,
  output logic [AW-1:0] curAddr,
  output logic          lastWord,
  output logic          isWrite
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] addrQ;
  logic [CW-1:0] leftQ;
  logic          writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      leftQ  <= '0;
      writeQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= startAddr;
      leftQ  <= startCount;
      writeQ <= startWrite;
    end else if (strobe.advance) begin
      addrQ <= addrQ + STEP;
      leftQ <= leftQ - 1'b1;
    end
  end

  assign curAddr  = addrQ;
  assign lastWord = (leftQ == CW'(1));
  assign isWrite  = writeQ;

endmodule

// File: rtl/stealControl.sv
module stealControl
  import busStealPkg::*;
#(
  parameter int MAX_WORDS = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xferStart,
  input  logic [CW-1:0] xferCount,
  input  logic          rgIn,
  input  logic          ready,
  input  logic          lastWord,
  input  logic          isWrite,
  output dpStrobe_t     strobe,
  output logic          rgDriveLow,
  output logic [2:0]    busStatus,
  output logic          statusOe,
  output logic          xferBusy,
  output logic          xferDone
);

  phase_t phase, phaseNext;
  logic   countOk, accept, showCode;

  assign countOk = (xferCount != '0) && (int'(xferCount) <= MAX_WORDS);
  assign accept  = (phase == PH_IDLE) && xferStart && countOk;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:    if (accept) phaseNext = PH_REQ;
      PH_REQ:     phaseNext = PH_WAITGNT;
      PH_WAITGNT: if (!rgIn) phaseNext = PH_LEAD;
      PH_LEAD:    phaseNext = PH_T1;
      PH_T1:      phaseNext = PH_T2;
      PH_T2:      phaseNext = PH_T3;
      PH_T3,
      PH_TW:      phaseNext = ready ? PH_T4 : PH_TW;
      PH_T4:      phaseNext = lastWord ? PH_REL : PH_T1;
      PH_REL:     phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe.load    = accept;
    strobe.advance = (phase == PH_T4) && !lastWord;
  end

  assign statusOe = (phase == PH_LEAD) || (phase == PH_T1) || (phase == PH_T2) ||
                    (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
  assign showCode = (phase == PH_LEAD) || (phase == PH_T1) || (phase == PH_T2) ||
                    ((phase == PH_T4) && !lastWord);
  assign busStatus  = (statusOe && showCode) ? (isWrite ? ST_WRITE : ST_READ) : ST_PASSIVE;
  assign rgDriveLow = (phase == PH_REQ) || (phase == PH_REL);
  assign xferBusy   = (phase != PH_IDLE);
  assign xferDone   = (phase == PH_REL);

endmodule

// File: rtl/busStealer.sv
module busStealer
  import busStealPkg::*;
#(
  parameter int AW = 20,
  parameter int WORD_BYTES = 2,
  parameter int MAX_WORDS = 8,
  parameter int CW = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xferStart,
  input  logic [AW-1:0] xferAddr,
  input  logic [CW-1:0] xferCount,
  input  logic          xferWrite,
  input  logic          ready,
  input  logic          rgIn,
  output logic          rgDriveLow,
  output logic [2:0]    busStatus,
  output logic          statusOe,
  output logic [AW-1:0] busAddr,
  output logic          xferBusy,
  output logic          xferDone
);

  dpStrobe_t strobe;
  logic      lastWord, isWrite;

  stealControl #(.MAX_WORDS(MAX_WORDS), .CW(CW)) ctrl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .xferCount(xferCount),
    .rgIn(rgIn), .ready(ready), .lastWord(lastWord), .isWrite(isWrite),
    .strobe(strobe), .rgDriveLow(rgDriveLow), .busStatus(busStatus),
    .statusOe(statusOe), .xferBusy(xferBusy), .xferDone(xferDone)
  );

  stealDatapath #(.AW(AW), .WORD_BYTES(WORD_BYTES), .CW(CW)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(xferAddr),
    .startCount(xferCount), .startWrite(xferWrite), .curAddr(busAddr),
    .lastWord(lastWord), .isWrite(isWrite)
  );

endmodule

// File: rtl/stealChecker.sv
module stealChecker #(
  parameter int AW = 20,
  parameter int WORD_BYTES = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          rgDriveLow,
  input logic [2:0]    busStatus,
  input logic          statusOe,
  input logic [AW-1:0] busAddr,
  input logic          xferBusy,
  input logic          xferDone
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !xferBusy |-> (!statusOe && !rgDriveLow && !xferDone));

  assert_pulse_one_clock_R2: assert property (@(posedge clk) disable iff (!rstN)
    rgDriveLow |=> !rgDriveLow);

  assert_code_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusOe && $past(statusOe) && busStatus != 3'b111 && $past(busStatus) != 3'b111)
    |-> $stable(busStatus));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusOe && $past(statusOe) && busAddr != $past(busAddr))
    |-> busAddr == $past(busAddr) + AW'(WORD_BYTES));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (rgDriveLow && !statusOe));

  assert_after_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferBusy);

  assert_legal_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusOe |-> (busStatus[2] && busStatus != 3'b100));

endmodule

bind busStealer stealChecker #(.AW(AW), .WORD_BYTES(WORD_BYTES)) chk (
  .clk(clk), .rstN(rstN), .rgDriveLow(rgDriveLow), .busStatus(busStatus),
  .statusOe(statusOe), .busAddr(busAddr), .xferBusy(xferBusy), .xferDone(xferDone)
);

// File: tb/busStealer_test.sv
module busStealer_test;
  localparam int AW = 20;
  localparam int CW = 4;
  localparam int MAXW = 8;

  logic clk = 0, rstN = 0;
  logic xferStart = 0, xferWrite = 0, ready = 1, hostPull = 0;
  logic [AW-1:0] xferAddr = '0;
  logic [CW-1:0] xferCount = '0;
  logic rgIn, rgDriveLow, statusOe, xferBusy, xferDone;
  logic [2:0] busStatus;
  logic [AW-1:0] busAddr;

  assign rgIn = ~(rgDriveLow | hostPull);

  busStealer uut (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .xferAddr(xferAddr),
    .xferCount(xferCount), .xferWrite(xferWrite), .ready(ready), .rgIn(rgIn),
    .rgDriveLow(rgDriveLow), .busStatus(busStatus), .statusOe(statusOe),
    .busAddr(busAddr), .xferBusy(xferBusy), .xferDone(xferDone)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, readyMode = 0, grantDelay = 1;
  int releases = 0;

  // reference model: 0 idle 1 req 2 wait 3 lead 4 t1 5 t2 6 t3 7 tw 8 t4 9 rel
  int mPh = 0, mLeft = 0;
  logic [AW-1:0] mAddr = '0;
  bit mWr = 0;

  always @(posedge clk) begin
    if (!rstN) mPh = 0;
    else case (mPh)
      0: if (xferStart && xferCount >= 1 && xferCount <= MAXW) begin
           mAddr = xferAddr; mLeft = xferCount; mWr = xferWrite; mPh = 1;
         end
      1: mPh = 2;
      2: if (hostPull) mPh = 3;
      3: mPh = 4;
      4: mPh = 5;
      5: mPh = 6;
      6, 7: mPh = ready ? 8 : 7;
      8: if (mLeft == 1) mPh = 9;
         else begin mAddr = mAddr + AW'(2); mLeft--; mPh = 4; end
      default: mPh = 0;
    endcase
  end

  function automatic string tagOf(int ph);
    case (ph)
      0: return "R1/R2";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      8: return "R6";
      9: return "R8";
      default: return "R5";
    endcase
  endfunction

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    bit eDrv, eOe, eBusy, eDone;
    logic [2:0] eSt;
    if (rstN) begin
      eDrv  = (mPh == 1 || mPh == 9);
      eOe   = (mPh >= 3 && mPh <= 8);
      eBusy = (mPh != 0);
      eDone = (mPh == 9);
      eSt   = 3'b111;
      if (mPh == 3 || mPh == 4 || mPh == 5 || (mPh == 8 && mLeft > 1))
        eSt = mWr ? 3'b110 : 3'b101;
      tests++;
      if (rgDriveLow !== eDrv || statusOe !== eOe || xferBusy !== eBusy ||
          xferDone !== eDone || busStatus !== eSt) begin
        fails++;
        $display("FAIL %s cyc %0d: drv/oe/busy/done/st = %b%b%b%b %b expected %b%b%b%b %b",
                 tagOf(mPh), cyc, rgDriveLow, statusOe, xferBusy, xferDone, busStatus,
                 eDrv, eOe, eBusy, eDone, eSt);
      end
      if (eOe) begin
        tests++;
        if (busAddr !== mAddr) begin
          fails++;
          $display("FAIL R7 cyc %0d: busAddr %h expected %h", cyc, busAddr, mAddr);
        end
      end
      if (statusOe && (busStatus[2] !== 1'b1 || busStatus == 3'b100)) begin
        fails++;
        $display("FAIL R9 cyc %0d: unused code %b expected 101/110/111", cyc, busStatus);
      end
    end
  end

  // host side of the handshake and ready pattern
  int hs = 0, hDelay = 0;
  always @(negedge clk) begin
    cyc++;
    ready = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    case (hs)
      0: if (rstN && rgDriveLow) begin hs = 1; hDelay = grantDelay; end
      1: if (hDelay <= 1) begin hostPull = 1; hs = 2; end else hDelay--;
      2: begin hostPull = 0; hs = 3; end
      3: if (rgDriveLow) begin releases++; hs = 0; end
      default: hs = 0;
    endcase
  end

  task automatic runXfer(input logic [AW-1:0] a, input int n, input bit wr);
    @(negedge clk);
    xferAddr = a; xferCount = CW'(n); xferWrite = wr; xferStart = 1;
    @(negedge clk);
    xferStart = 0;
    while (mPh != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;  // R1 reset state
    if (rgDriveLow || statusOe || xferBusy || xferDone || busStatus !== 3'b111) begin
      fails++;
      $display("FAIL R1: reset outputs %b%b%b%b %b expected 0000 111",
               rgDriveLow, statusOe, xferBusy, xferDone, busStatus);
    end
    rstN = 1;
    // R4 R5 single read, no waits
    runXfer(20'h01000, 1, 0);
    // R5 R6 R7 write of three words with wait phases
    readyMode = 1; grantDelay = 3;
    runXfer(20'h02220, 3, 1);
    // R7 maximum count, address wraps
    readyMode = 0; grantDelay = 1;
    runXfer(20'hFFFFA, 8, 0);
    // R2 count 0 and count above maximum are ignored
    runXfer(20'h00100, 0, 1);
    runXfer(20'h00100, 9, 1);
    // R2 start while busy ignored, R3 long grant wait
    grantDelay = 6; readyMode = 1;
    @(negedge clk);
    xferAddr = 20'h30000; xferCount = 4'd2; xferWrite = 1; xferStart = 1;
    @(negedge clk);
    xferAddr = 20'h40000; xferCount = 4'd5; xferWrite = 0;
    @(negedge clk);
    xferStart = 0;
    while (mPh != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    tests++;  // R8 one release per accepted transfer
    if (releases != 4) begin
      fails++;
      $display("FAIL R8: releases %0d expected 4", releases);
    end
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end
endmodule